// File: doc/BRIEF.md
# Port Overcurrent Fault Timer

This block sits beside the pass-switch control of a single power-sourcing Ethernet port and decides when the port must be shut off for drawing too much current. On every ADC sample strobe it receives the port current in milliamps and the output voltage in volts. From these it forms the product and compares it with a power budget chosen by the granted class. A leaky-bucket timer fills quickly while the port is over budget and drains at one sixteenth of that rate while it is under. When the bucket is full, the block raises a fault.

Two further guards run alongside the bucket. From the moment the port is enabled until the gate driver reports the switch fully on, a fixed inrush limit is selected and a window timer runs; if the window expires, a fault is raised. On a high-power class 4 port, a second timer counts consecutive samples at or above the high-power current limit and trips when the limit is held too long. Every fault is a one-cycle pulse with a 2-bit cause code. After a fault, the current-limit selection is forced to "off", which commands the pass switch open until the port is disabled and enabled again.

All timing is counted in sample strobes. With the default parameters, one strobe stands for 1 ms.

Top module: `ovl_fault_timer`

## Requirements
- R1: After reset and whenever `port_en` is low, `lim_sel` is 0 (switch off) and no fault is pulsed. Deasserting `port_en` empties the overload bucket and the current-limit timer, so a full 60-strobe overload run is needed again after re-enabling.
- R2: From enable until `gate_full` is seen high, `lim_sel` is 1 (fixed inrush limit). Over-budget samples during this phase do not fill the overload bucket.
- R3: If `gate_full` stays low through 75 sample strobes after enable, the 75th strobe produces a fault with cause 3 (inrush timeout). If `gate_full` rises before that strobe, no such fault occurs.
- R4: A sample is over budget when `i_ma * v_out >= budget`. The budget, in mA·V, is chosen by `pd_class` as follows:
  - class 1: 4200
  - class 2: 7350
  - class 4 with `hi_pwr`: 31500
  - all other codes (0, 3, class 4 without `hi_pwr`, and codes 5 to 7): 16170
- R5: Starting from an empty bucket, 60 consecutive over-budget strobes after gate-on raise a fault with cause 1 on the 60th strobe, and not before.
- R6: Each under-budget strobe drains 1/16 of one over-budget step. For example, 59 over-budget strobes, then 16 under-budget strobes, need 2 more over-budget strobes to trip.
- R7: The bucket does not go below empty: under-budget strobes on an empty bucket leave it empty. The bucket never holds more than its timeout value.
- R8: On a port with `hi_pwr` high and `pd_class` 4, the current is at the limit when `i_ma >= 684`. The 16th consecutive strobe at the limit raises a fault with cause 2. A strobe below the limit restarts the count.
- R9: When the current-limit trip and the overload trip fall on the same strobe, the cause reported is 2.
- R10: After a fault, `lim_sel` is 0, and no further fault pulses appear until `port_en` has been deasserted.
- R11: After gate-on, `lim_sel` is 3 for a `hi_pwr` class 4 port and 2 for any other port.
- R12: `fault_pulse` is high for exactly the one cycle after the clock edge that sampled the tripping strobe. `fault_cause` is 0 whenever `fault_pulse` is low. Cause codes: 1 = overload, 2 = current limit, 3 = inrush timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Port power enable; low clears all timers |
| smp_vld | input | 1 | One-cycle strobe marking a new current/voltage sample |
| i_ma | input | 12 | Port current in mA |
| v_out | input | 8 | Output voltage in V |
| pd_class | input | 3 | Granted class code |
| hi_pwr | input | 1 | High-power grant flag |
| gate_full | input | 1 | Pass switch reports fully on |
| fault_pulse | output | 1 | One-cycle fault indication |
| fault_cause | output | 2 | Fault cause code, 0 when idle |
| lim_sel | output | 2 | Current-limit selection: 0 off, 1 inrush, 2 class, 3 high power |

## Verification
On a high-power class 4 port, the overload bucket and the current-limit timer can expire on the same strobe. The bench provokes this with 44 strobes that are over budget but below the 684 mA limit, followed by 16 strobes that are both over budget and at the limit. Both timers then complete on that final strobe. The reported cause must be 2, and only one pulse may appear. Random sessions across all classes and voltages, with a bench-side model of both timers, also reach this coincidence and the drain/fill interleavings.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

  localparam int BUDGET_W = 16;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_OVL    = 2'd1,
    CAUSE_ILIM   = 2'd2,
    CAUSE_INRUSH = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    LIM_OFF    = 2'd0,
    LIM_INRUSH = 2'd1,
    LIM_CLASS  = 2'd2,
    LIM_HIPWR  = 2'd3
  } lim_e;

  // Power budget in mA*V selected by granted class and high-power grant.
  function automatic logic [BUDGET_W-1:0] class_budget(input logic [2:0] cls, input logic hp);
    logic [BUDGET_W-1:0] b;
    case (cls)
      3'd1:    b = BUDGET_W'(4200);
      3'd2:    b = BUDGET_W'(7350);
      3'd4:    b = hp ? BUDGET_W'(31500) : BUDGET_W'(16170);
      default: b = BUDGET_W'(16170);
    endcase
    return b;
  endfunction

endpackage

// File: rtl/inrush_guard.sv
module inrush_guard #(
  parameter int WIN = 75,
  localparam int CW = $clog2(WIN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic smp,
  input  logic gate_full,
  input  logic hold,
  output logic done,
  output logic expire
);

  logic [CW-1:0] cnt;

  assign expire = en && !done && !gate_full && !hold && smp && (cnt == CW'(WIN - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (gate_full) begin
        done <= 1'b1;
      end else if (smp && cnt != CW'(WIN)) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/bucket_timer.sv
module bucket_timer #(
  parameter int WIN = 60,
  parameter int SUB = 16,
  parameter int LW  = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          smp,
  input  logic          over,
  output logic          expire,
  output logic [LW-1:0] level
);

  localparam int TOP = WIN * SUB;

  logic [LW-1:0] up;
  logic          hit;

  assign up     = level + LW'(SUB);
  assign hit    = (up >= LW'(TOP));
  assign expire = !clr && smp && over && hit;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      level <= '0;
    end else if (smp) begin
      if (over) begin
        level <= hit ? LW'(TOP) : up;
      end else if (level != '0) begin
        level <= level - 1'b1;
      end
    end
  end

endmodule

// File: rtl/streak_timer.sv
module streak_timer #(
  parameter int WIN = 15,
  localparam int CW = $clog2(WIN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic smp,
  input  logic at_lim,
  output logic expire
);

  logic [CW-1:0] cnt;

  assign expire = !clr && smp && at_lim && (cnt == CW'(WIN));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (smp) begin
      if (!at_lim) begin
        cnt <= '0;
      end else if (cnt != CW'(WIN)) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ovl_fault_timer.sv
module ovl_fault_timer
  import ovl_pkg::*;
#(
  parameter int IW         = 12,
  parameter int VW         = 8,
  parameter int OVL_WIN    = 60,
  parameter int SUB        = 16,
  parameter int ILIM_WIN   = 15,
  parameter int INRUSH_WIN = 75,
  parameter int ILIM_HP_MA = 684
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          port_en,
  input  logic          smp_vld,
  input  logic [IW-1:0] i_ma,
  input  logic [VW-1:0] v_out,
  input  logic [2:0]    pd_class,
  input  logic          hi_pwr,
  input  logic          gate_full,
  output logic          fault_pulse,
  output logic [1:0]    fault_cause,
  output logic [1:0]    lim_sel
);

  localparam int PW      = IW + VW;
  localparam int BKT_TOP = OVL_WIN * SUB;
  localparam int LW      = $clog2(BKT_TOP + SUB + 1);

  logic [PW-1:0]       prod;
  logic [BUDGET_W-1:0] budget;
  logic                over_thr, at_limit, hp_port;
  logic                gate_done, tripped, run_act, trip_any;
  logic                inr_exp, ovl_exp, ilim_exp;
  logic [LW-1:0]       bkt_level;
  cause_e              cause_nxt;
  lim_e                lim_nxt;

  assign prod     = {{VW{1'b0}}, i_ma} * {{IW{1'b0}}, v_out};
  assign budget   = class_budget(pd_class, hi_pwr);
  assign over_thr = (prod >= PW'(budget));
  assign at_limit = (i_ma >= IW'(ILIM_HP_MA));
  assign hp_port  = hi_pwr && (pd_class == 3'd4);
  assign run_act  = port_en && gate_done && !tripped;

  inrush_guard #(.WIN(INRUSH_WIN)) u_inrush (
    .clk       (clk),
    .rst       (rst),
    .en        (port_en),
    .smp       (smp_vld),
    .gate_full (gate_full),
    .hold      (tripped),
    .done      (gate_done),
    .expire    (inr_exp)
  );

  bucket_timer #(.WIN(OVL_WIN), .SUB(SUB), .LW(LW)) u_bucket (
    .clk    (clk),
    .rst    (rst),
    .clr    (!run_act),
    .smp    (smp_vld),
    .over   (over_thr),
    .expire (ovl_exp),
    .level  (bkt_level)
  );

  streak_timer #(.WIN(ILIM_WIN)) u_streak (
    .clk    (clk),
    .rst    (rst),
    .clr    (!(run_act && hp_port)),
    .smp    (smp_vld),
    .at_lim (at_limit),
    .expire (ilim_exp)
  );

  assign trip_any = inr_exp || ovl_exp || ilim_exp;

  always_comb begin
    if (ilim_exp)      cause_nxt = CAUSE_ILIM;
    else if (ovl_exp)  cause_nxt = CAUSE_OVL;
    else if (inr_exp)  cause_nxt = CAUSE_INRUSH;
    else               cause_nxt = CAUSE_NONE;
  end

  always_comb begin
    if (!port_en || tripped || trip_any) lim_nxt = LIM_OFF;
    else if (!gate_done)                 lim_nxt = LIM_INRUSH;
    else if (hp_port)                    lim_nxt = LIM_HIPWR;
    else                                 lim_nxt = LIM_CLASS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tripped     <= 1'b0;
      fault_pulse <= 1'b0;
      fault_cause <= CAUSE_NONE;
      lim_sel     <= LIM_OFF;
    end else begin
      tripped     <= port_en && (tripped || trip_any);
      fault_pulse <= trip_any;
      fault_cause <= cause_nxt;
      lim_sel     <= lim_nxt;
    end
  end

endmodule

// File: rtl/ovl_fault_chk.sv
module ovl_fault_chk #(
  parameter int LW  = 10,
  parameter int TOP = 960
) (
  input logic          clk,
  input logic          rst,
  input logic          port_en,
  input logic          smp_vld,
  input logic          fault_pulse,
  input logic [1:0]    fault_cause,
  input logic [1:0]    lim_sel,
  input logic          run_act,
  input logic          over_thr,
  input logic [LW-1:0] bkt_level
);

  AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (rst) fault_pulse |=> !fault_pulse); // R10
  AST_CAUSE_SET: assert property (@(posedge clk) disable iff (rst) fault_pulse |-> fault_cause != 2'd0); // R12
  AST_CAUSE_QUIET: assert property (@(posedge clk) disable iff (rst) !fault_pulse |-> fault_cause == 2'd0); // R12
  AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst) fault_pulse |-> $past(smp_vld)); // R12
  AST_OFF_ON_FAULT: assert property (@(posedge clk) disable iff (rst) fault_pulse |-> lim_sel == 2'd0); // R10
  AST_OFF_DISABLED: assert property (@(posedge clk) disable iff (rst) !port_en |=> lim_sel == 2'd0); // R1
  AST_BKT_CAP: assert property (@(posedge clk) disable iff (rst) bkt_level <= LW'(TOP)); // R7
  AST_BKT_LEAK: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && run_act && !over_thr && bkt_level != '0) |=> bkt_level == $past(bkt_level) - 1'b1); // R6
  AST_BKT_IDLE: assert property (@(posedge clk) disable iff (rst) !run_act |=> bkt_level == '0); // R1

endmodule

bind ovl_fault_timer ovl_fault_chk #(.LW(LW), .TOP(BKT_TOP)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .port_en     (port_en),
  .smp_vld     (smp_vld),
  .fault_pulse (fault_pulse),
  .fault_cause (fault_cause),
  .lim_sel     (lim_sel),
  .run_act     (run_act),
  .over_thr    (over_thr),
  .bkt_level   (bkt_level)
);

// File: tb/ovl_fault_timer_tb.sv
module ovl_fault_timer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        port_en = 1'b0;
  logic        smp_vld = 1'b0;
  logic [11:0] i_ma = '0;
  logic [7:0]  v_out = '0;
  logic [2:0]  pd_class = '0;
  logic        hi_pwr = 1'b0;
  logic        gate_full = 1'b0;
  logic        fault_pulse;
  logic [1:0]  fault_cause;
  logic [1:0]  lim_sel;

  int checks = 0;
  int errors = 0;
  int m_lvl, m_hpc, m_inr;
  bit m_en, m_done, m_trip;
  int last_cause;

  always #10 clk = ~clk;

  ovl_fault_timer u_dut (
    .clk(clk), .rst(rst), .port_en(port_en), .smp_vld(smp_vld),
    .i_ma(i_ma), .v_out(v_out), .pd_class(pd_class), .hi_pwr(hi_pwr),
    .gate_full(gate_full), .fault_pulse(fault_pulse),
    .fault_cause(fault_cause), .lim_sel(lim_sel)
  );

  function automatic int budget_of(int cls, bit hp);
    case (cls)
      1: return 4200;
      2: return 7350;
      4: return hp ? 31500 : 16170;
      default: return 16170;
    endcase
  endfunction

  function automatic bit hp_now();
    return hi_pwr && (pd_class == 3'd4);
  endfunction

  function automatic int exp_lim();
    if (!m_en || m_trip) return 0;
    if (!m_done) return 1;
    return hp_now() ? 3 : 2;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic do_sample(int i, int v, string tag);
    int cause;
    bit over, lim;
    @(negedge clk);
    i_ma = 12'(i); v_out = 8'(v); smp_vld = 1'b1;
    cause = 0;
    if (m_en && !m_trip) begin
      if (!m_done) begin
        if (m_inr == 74) cause = 3;
        if (m_inr < 75) m_inr++;
      end else begin
        over = (i * v) >= budget_of(int'(pd_class), hi_pwr);
        lim  = hp_now() && (i >= 684);
        if (lim && m_hpc == 15) cause = 2;
        else if (over && m_lvl + 16 >= 960) cause = 1;
        if (over) m_lvl = (m_lvl + 16 > 960) ? 960 : m_lvl + 16;
        else if (m_lvl > 0) m_lvl--;
        if (!hp_now() || !lim) m_hpc = 0;
        else if (m_hpc < 15) m_hpc++;
      end
      if (cause != 0) begin m_trip = 1; m_lvl = 0; m_hpc = 0; end
    end
    last_cause = cause;
    @(negedge clk);
    smp_vld = 1'b0;
    chk(tag, "pulse", int'(fault_pulse), int'(cause != 0));
    chk(tag, "cause", int'(fault_cause), cause);
    chk(tag, "lim_sel", int'(lim_sel), exp_lim());
  endtask

  task automatic en_port();
    @(negedge clk);
    port_en = 1'b1; gate_full = 1'b0;
    m_en = 1; m_done = 0; m_inr = 0; m_trip = 0; m_lvl = 0; m_hpc = 0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic gate_on();
    @(negedge clk);
    gate_full = 1'b1; m_done = 1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic dis_port();
    @(negedge clk);
    port_en = 1'b0; gate_full = 1'b0;
    m_en = 0; m_done = 0; m_trip = 0; m_lvl = 0; m_hpc = 0; m_inr = 0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic start(int cls, bit hp);
    dis_port();
    pd_class = 3'(cls); hi_pwr = hp;
    en_port();
    gate_on();
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic probe(int cls, bit hp, int i, int v, int exp_cause);
    start(cls, hp);
    for (int k = 0; k < 59; k++) do_sample(650, 57, "R4");
    do_sample(i, v, "R4");
    chk("R4", "probe cause", last_cause, exp_cause);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd24680));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset lim_sel", int'(lim_sel), 0);
    chk("R1", "reset pulse", int'(fault_pulse), 0);

    // R2 / R11 / R5 / R12 / R10
    pd_class = 3'd0; hi_pwr = 1'b0;
    en_port();
    chk("R2", "inrush lim_sel", int'(lim_sel), 1);
    for (int k = 0; k < 10; k++) do_sample(800, 50, "R2");
    gate_on();
    chk("R11", "class lim_sel", int'(lim_sel), 2);
    for (int k = 0; k < 59; k++) do_sample(800, 50, "R5");
    chk("R5", "no early trip", int'(m_trip), 0);
    do_sample(800, 50, "R5");
    chk("R5", "trip on 60th", last_cause, 1);
    @(negedge clk);
    chk("R12", "pulse gone", int'(fault_pulse), 0);
    chk("R10", "off after fault", int'(lim_sel), 0);
    for (int k = 0; k < 5; k++) do_sample(900, 55, "R10");

    // R1: disable clears the bucket
    start(0, 0);
    for (int k = 0; k < 50; k++) do_sample(800, 50, "R1");
    start(0, 0);
    for (int k = 0; k < 59; k++) do_sample(800, 50, "R1");
    do_sample(800, 50, "R1");
    chk("R1", "full run after re-enable", last_cause, 1);

    // R6: drain at 1/16
    start(2, 0);
    for (int k = 0; k < 59; k++) do_sample(300, 50, "R6");
    for (int k = 0; k < 16; k++) do_sample(10, 50, "R6");
    do_sample(300, 50, "R6");
    chk("R6", "no trip after drain", last_cause, 0);
    do_sample(300, 50, "R6");
    chk("R6", "trip after one more", last_cause, 1);

    // R7: empty floor
    start(1, 0);
    for (int k = 0; k < 30; k++) do_sample(5, 50, "R7");
    for (int k = 0; k < 59; k++) do_sample(200, 50, "R7");
    do_sample(200, 50, "R7");
    chk("R7", "trip on 60th from floor", last_cause, 1);

    // R4: budget boundaries
    probe(0, 0, 330, 49, 1);  probe(0, 0, 329, 49, 0);
    probe(1, 0, 84, 50, 1);   probe(1, 0, 83, 50, 0);
    probe(2, 0, 150, 49, 1);  probe(2, 0, 149, 49, 0);
    probe(3, 0, 330, 49, 1);  probe(3, 0, 329, 49, 0);
    probe(4, 0, 330, 49, 1);  probe(4, 0, 329, 49, 0);
    probe(4, 1, 630, 50, 1);  probe(4, 1, 629, 50, 0);
    probe(6, 0, 330, 49, 1);  probe(6, 1, 329, 49, 0);

    // R3: inrush timeout
    dis_port(); pd_class = 3'd0; hi_pwr = 1'b0; en_port();
    for (int k = 0; k < 74; k++) do_sample(100, 50, "R3");
    do_sample(100, 50, "R3");
    chk("R3", "timeout on 75th", last_cause, 3);
    dis_port(); en_port();
    for (int k = 0; k < 74; k++) do_sample(100, 50, "R3");
    gate_on();
    for (int k = 0; k < 5; k++) do_sample(100, 50, "R3");
    chk("R3", "no timeout after gate", int'(m_trip), 0);

    // R8 / R11: high-power current-limit timer
    start(4, 1);
    chk("R11", "hipwr lim_sel", int'(lim_sel), 3);
    for (int k = 0; k < 15; k++) do_sample(700, 44, "R8");
    do_sample(100, 44, "R8");
    for (int k = 0; k < 15; k++) do_sample(700, 44, "R8");
    chk("R8", "no trip at 15", int'(m_trip), 0);
    do_sample(700, 44, "R8");
    chk("R8", "trip on 16th", last_cause, 2);

    // R9: coincident trips
    start(4, 1);
    for (int k = 0; k < 44; k++) do_sample(650, 57, "R9");
    for (int k = 0; k < 15; k++) do_sample(700, 50, "R9");
    do_sample(700, 50, "R9");
    chk("R9", "coincident cause", last_cause, 2);

    // Random sessions
    for (int s = 0; s < 40; s++) begin
      dis_port();
      pd_class = 3'($urandom % 8);
      hi_pwr = 1'($urandom % 2);
      en_port();
      if (($urandom % 10) != 0) gate_on();
      for (int k = 0; k < 120; k++) begin
        int ii = int'($urandom % 900);
        int vv = 44 + int'($urandom % 14);
        do_sample(ii, vv, "R4");
      end
    end

    report();
    $finish;
  end

endmodule